// File: doc/BRIEF.md
# Synchronous Clock Stop Controller

This block halts and resumes a set of clock outputs that are all derived from one base clock, while the base clock itself keeps running. A stop can be requested in two ways: through an active-low input pin, or through a run/stop bit in a software-written control register. Each output also has a free-run mask bit. When that bit is set, the output keeps toggling no matter what either stop source asks for.

Each output has an enable register that updates only while the base clock is low. A gating AND follows it. Because of this, a stopped output always rests low, and no output ever shows a shortened high or low pulse. The pin passes through a synchronizer before it is used. A readback signal reports the combined run state, so software reading the stop bit sees 0 whenever the outputs are halted by either source.

Top module: `clkstop_ctrl`

## Requirements
- R1: `stop_pin_n` is active low and is sampled on rising edges of `clk_base`. If the pin is first sampled low at edge k, every non-masked output produces its high pulses beginning at edges k and k+1, and no high pulse after that.
- R2: A register write (`reg_we`=1 at rising edge k) with `reg_wstop_n`=0 stops the non-masked outputs. The high pulse beginning at edge k is the last one. `reg_wfreerun` is written at the same edge.
- R3: The stop request is the OR of the two sources. Outputs run only while both the synchronized pin and the register bit are 1. All four combinations of pin and register bit are covered.
- R4: A stopped output rests at logic 0, including while `clk_base` is high, and `gate_en` for it reads 0.
- R5: An output whose free-run mask bit is 1 keeps one high pulse per base-clock period, whatever the stop sources say.
- R6: If the pin is first sampled high at edge k and the register bit is 1, every output is high again from edge k+2. This is within two base-clock periods of release.
- R7: `reg_rd_stop` is 1 only when the register bit is 1 and the synchronized pin is 1. It follows a pin change two rising edges after the sampling edge, and a register write right after the write edge.
- R8: No output high or low pulse is shorter than half a base-clock period.
- R9: After reset, the register stop bit is 1, all mask bits are 0, all enables are 1, `reg_rd_stop` is 1, and all outputs toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base | input | 1 | Free-running base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_pin_n | input | 1 | Asynchronous active-low stop request pin |
| reg_we | input | 1 | Control register write strobe |
| reg_wstop_n | input | 1 | Register run bit to write (0 = stop) |
| reg_wfreerun | input | N_OUT | Free-run mask to write (1 = never stop) |
| reg_rd_stop | output | 1 | Readback of combined run state (0 = halted) |
| gate_en | output | N_OUT | Per-output gate enable, changes only while the clock is low |
| clk_out | output | N_OUT | Gated clock outputs |

## Verification
A fault in the synchronizer depth shows as a stop or restart one edge early or late. Counting output rising edges after each pin change exposes this within three periods. A fault in the enable timing, such as an enable register clocked on the rising edge, produces a truncated pulse on the first stop or restart, and pulse-width monitors on every output catch it. A wrong combine of the two sources, or a wrong readback, appears within three cycles in the four pin/register combinations. A mask fault shows as a missing or extra toggle while the outputs are held stopped.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
   // Implementation chosen for the per-output enable holding element
   typedef enum logic {
      GATE_NEGFF = 1'b0,   // falling-edge flop
      GATE_LATCH = 1'b1    // transparent-low latch
   } gate_style_e;

   localparam int MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   localparam int LAST = STAGES - 1;

   logic [STAGES-1:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= {STAGES{RST_VAL}};
      else        sr <= {sr[STAGES-2:0], d_async};
   end

   assign q_sync = sr[LAST];
endmodule

// File: rtl/clkstop_req.sv
`timescale 1ns/1ps
module clkstop_req #(
   parameter int N_OUT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_run_sync,
   input  logic             we,
   input  logic             wstop_n,
   input  logic [N_OUT-1:0] wfreerun,
   output logic             rd_run,
   output logic [N_OUT-1:0] run_vec,
   output logic [N_OUT-1:0] mask_q
);
   logic reg_run_q;
   logic stop_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_run_q <= 1'b1;
         mask_q    <= '0;
      end else if (we) begin
         reg_run_q <= wstop_n;
         mask_q    <= wfreerun;
      end
   end

   // either source low requests a stop
   assign stop_req = ~pin_run_sync | ~reg_run_q;
   assign rd_run   = ~stop_req;
   assign run_vec  = mask_q | {N_OUT{~stop_req}};
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
   parameter clkstop_pkg::gate_style_e STYLE = clkstop_pkg::GATE_NEGFF
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic en_o,
   output logic clk_o
);
   generate
      if (STYLE == clkstop_pkg::GATE_LATCH) begin : g_latch
         logic en_l;
         always_latch begin
            if (!rst_n)    en_l = 1'b1;
            else if (!clk) en_l = run_i;
         end
         assign en_o = en_l;
      end else begin : g_negff
         logic en_f;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) en_f <= 1'b1;
            else        en_f <= run_i;
         end
         assign en_o = en_f;
      end
   endgenerate

   assign clk_o = clk & en_o;
endmodule

// File: rtl/clkstop_ctrl.sv
`timescale 1ns/1ps
module clkstop_ctrl #(
   parameter int                       N_OUT       = 4,
   parameter int                       SYNC_STAGES = 2,
   parameter clkstop_pkg::gate_style_e GATE_STYLE  = clkstop_pkg::GATE_NEGFF
) (
   input  logic             clk_base,
   input  logic             rst_n,
   input  logic             stop_pin_n,
   input  logic             reg_we,
   input  logic             reg_wstop_n,
   input  logic [N_OUT-1:0] reg_wfreerun,
   output logic             reg_rd_stop,
   output logic [N_OUT-1:0] gate_en,
   output logic [N_OUT-1:0] clk_out
);
   generate
      if (N_OUT < 1) begin : g_bad_nout
         $error("clkstop_ctrl: N_OUT must be at least 1");
      end
      if (SYNC_STAGES < clkstop_pkg::MIN_SYNC_STAGES) begin : g_bad_sync
         $error("clkstop_ctrl: SYNC_STAGES below minimum");
      end
   endgenerate

   logic             pin_run_sync;
   logic [N_OUT-1:0] run_vec;
   logic [N_OUT-1:0] mask_q;

   clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk_base),
      .rst_n   (rst_n),
      .d_async (stop_pin_n),
      .q_sync  (pin_run_sync)
   );

   clkstop_req #(.N_OUT(N_OUT)) u_req (
      .clk          (clk_base),
      .rst_n        (rst_n),
      .pin_run_sync (pin_run_sync),
      .we           (reg_we),
      .wstop_n      (reg_wstop_n),
      .wfreerun     (reg_wfreerun),
      .rd_run       (reg_rd_stop),
      .run_vec      (run_vec),
      .mask_q       (mask_q)
   );

   for (genvar g = 0; g < N_OUT; g++) begin : g_out
      clkstop_gate #(.STYLE(GATE_STYLE)) u_gate (
         .clk   (clk_base),
         .rst_n (rst_n),
         .run_i (run_vec[g]),
         .en_o  (gate_en[g]),
         .clk_o (clk_out[g])
      );
   end
endmodule

// File: rtl/clkstop_chk.sv
`timescale 1ns/1ps
module clkstop_chk #(
   parameter int N_OUT       = 4,
   parameter int SYNC_STAGES = 2
) (
   input logic             clk_base,
   input logic             rst_n,
   input logic             stop_pin_n,
   input logic             reg_rd_stop,
   input logic [N_OUT-1:0] mask_q,
   input logic [N_OUT-1:0] gate_en
);
   logic [1:0] age;

   always_ff @(posedge clk_base or negedge rst_n) begin
      if (!rst_n)          age <= 2'd0;
      else if (age != 2'd2) age <= age + 2'd1;
   end

   // R3: halted readback means every non-masked enable is off
   p_stopped_r3: assert property (@(posedge clk_base) disable iff (!rst_n)
      !reg_rd_stop |-> ((gate_en & ~mask_q) == '0));

   // R6: running readback means every enable is on
   p_running_r6: assert property (@(posedge clk_base) disable iff (!rst_n)
      reg_rd_stop |-> (&gate_en));

   // R5: a masked output is never disabled
   p_freerun_r5: assert property (@(posedge clk_base) disable iff (!rst_n)
      ((gate_en & mask_q) == mask_q));

   generate
      if (SYNC_STAGES == 2) begin : g_rb
         // R7: pin sampled low two edges ago forces a halted readback
         p_readback_r7: assert property (@(posedge clk_base) disable iff (!rst_n)
            ((age == 2'd2) && !$past(stop_pin_n, 2)) |-> !reg_rd_stop);
      end
   endgenerate
endmodule

bind clkstop_ctrl clkstop_chk #(.N_OUT(N_OUT), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk_base    (clk_base),
   .rst_n       (rst_n),
   .stop_pin_n  (stop_pin_n),
   .reg_rd_stop (reg_rd_stop),
   .mask_q      (mask_q),
   .gate_en     (gate_en)
);

// File: tb/sim_clkstop_ctrl.sv
`timescale 1ns/1ps
module sim_clkstop_ctrl;
   localparam int      N    = 4;
   localparam realtime PER  = 20.0;
   localparam realtime HALF = 10.0;

   logic         clk_base = 1'b0;
   logic         rst_n = 1'b0;
   logic         stop_pin_n = 1'b1;
   logic         reg_we = 1'b0;
   logic         reg_wstop_n = 1'b1;
   logic [N-1:0] reg_wfreerun = '0;
   logic         reg_rd_stop;
   logic [N-1:0] gate_en;
   logic [N-1:0] clk_out;

   int n_chk  = 0;
   int n_fail = 0;
   int rise_cnt [N];
   int short_cnt[N];

   always #(PER/2) clk_base = ~clk_base;

   clkstop_ctrl #(.N_OUT(N)) u0 (
      .clk_base(clk_base), .rst_n(rst_n), .stop_pin_n(stop_pin_n),
      .reg_we(reg_we), .reg_wstop_n(reg_wstop_n), .reg_wfreerun(reg_wfreerun),
      .reg_rd_stop(reg_rd_stop), .gate_en(gate_en), .clk_out(clk_out)
   );

   // pulse monitors (R8)
   for (genvar g = 0; g < N; g++) begin : g_mon
      realtime t_r = 0.0;
      realtime t_f = 0.0;
      initial begin rise_cnt[g] = 0; short_cnt[g] = 0; end
      always @(posedge clk_out[g]) begin
         rise_cnt[g]++;
         if (t_f > 0.0 && ($realtime - t_f) < HALF - 0.001) short_cnt[g]++;
         t_r = $realtime;
      end
      always @(negedge clk_out[g]) begin
         if (t_r > 0.0 && ($realtime - t_r) < HALF - 0.001) short_cnt[g]++;
         t_f = $realtime;
      end
   end

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic wreg(logic run_bit, logic [N-1:0] mask);
      @(negedge clk_base);
      reg_we = 1'b1; reg_wstop_n = run_bit; reg_wfreerun = mask;
      @(negedge clk_base);
      reg_we = 1'b0;
   endtask

   task automatic t_reset();
      int s;
      repeat (3) @(negedge clk_base);
      rst_n = 1'b1;
      #1;
      chk("R9 readback", int'(reg_rd_stop), 1);
      chk("R9 enables", int'(gate_en), 4'hF);
      s = rise_cnt[0];
      repeat (3) @(posedge clk_base);
      #1;
      chk("R9 toggling", rise_cnt[0] - s, 3);
   endtask

   task automatic t_pin_stop();
      int s;
      @(negedge clk_base);
      stop_pin_n = 1'b0;
      s = rise_cnt[1];
      @(posedge clk_base); #1;
      chk("R7 readback after first edge", int'(reg_rd_stop), 1);
      @(posedge clk_base); #1;
      chk("R7 readback after second edge", int'(reg_rd_stop), 0);
      repeat (4) @(posedge clk_base);
      #1;
      chk("R1 pulses after pin low", rise_cnt[1] - s, 2);
      chk("R4 outputs low while clock high", int'(clk_out), 0);
      chk("R4 enables off", int'(gate_en), 0);
   endtask

   task automatic t_restart();
      @(negedge clk_base);
      stop_pin_n = 1'b1;
      @(posedge clk_base); #1;
      chk("R6 still stopped at sampling edge", int'(clk_out), 0);
      @(posedge clk_base); #1;
      chk("R6 still stopped one edge later", int'(clk_out), 0);
      chk("R7 readback after release", int'(reg_rd_stop), 1);
      @(posedge clk_base); #1;
      chk("R6 running two edges later", int'(clk_out), 4'hF);
   endtask

   task automatic t_reg_stop();
      int s;
      @(negedge clk_base);
      reg_we = 1'b1; reg_wstop_n = 1'b0; reg_wfreerun = '0;
      s = rise_cnt[2];
      @(posedge clk_base); #1;
      chk("R7 readback after register write", int'(reg_rd_stop), 0);
      @(negedge clk_base);
      reg_we = 1'b0;
      repeat (3) @(posedge clk_base);
      #1;
      chk("R2 pulses after register stop", rise_cnt[2] - s, 1);
      chk("R4 outputs low after register stop", int'(clk_out), 0);
   endtask

   task automatic t_freerun();
      int s[N];
      stop_pin_n = 1'b0;
      wreg(1'b0, 4'b0101);
      for (int i = 0; i < N; i++) s[i] = rise_cnt[i];
      repeat (4) @(posedge clk_base);
      #1;
      chk("R5 masked output 0 toggles", rise_cnt[0] - s[0], 4);
      chk("R5 masked output 2 toggles", rise_cnt[2] - s[2], 4);
      chk("R5 unmasked output 1 held", rise_cnt[1] - s[1], 0);
      chk("R5 unmasked output 3 held", rise_cnt[3] - s[3], 0);
      stop_pin_n = 1'b1;
      wreg(1'b1, '0);
      repeat (3) @(posedge clk_base);
   endtask

   task automatic t_combos();
      for (int p = 0; p < 2; p++) begin
         for (int r = 0; r < 2; r++) begin
            @(negedge clk_base);
            stop_pin_n = p[0];
            wreg(r[0], '0);
            repeat (3) @(posedge clk_base);
            #1;
            chk($sformatf("R7 readback pin=%0d reg=%0d", p, r), int'(reg_rd_stop), p & r);
            chk($sformatf("R3 outputs pin=%0d reg=%0d", p, r), int'(clk_out), (p & r) ? 4'hF : 0);
         end
      end
   endtask

   task automatic t_pulses();
      int tot = 0;
      for (int i = 0; i < N; i++) tot += short_cnt[i];
      chk("R8 short pulses", tot, 0);
   endtask

   initial begin
      #(PER * 100000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_pin_stop();
      t_restart();
      t_reg_stop();
      wreg(1'b1, '0);
      repeat (3) @(posedge clk_base);
      t_freerun();
      t_combos();
      stop_pin_n = 1'b1;
      wreg(1'b1, '0);
      repeat (4) @(posedge clk_base);
      t_pulses();
      finish_run();
   end
endmodule